// File: doc/BRIEF.md
# Lane Write-Enable Mask Generator

This combinational unit turns a compact write-enable request into a 64-bit byte-enable mask for one 64-byte destination register row. A request carries a mode, a count or index value N and a lane-width code. From these the unit decides which lanes of the row may be written, then spreads each lane decision over the bytes that the lane covers. Downstream, a row-write path ANDs this mask into its byte strobes.

Two request formats are accepted, selected by one input. The wide format uses a 3-bit mode and a 6-bit value and adds a few extra selections. The narrow format uses a 2-bit mode and a 5-bit value, and it has a lane-width code that keeps only the low byte of each 16-bit lane. One wide-format selection enables every lane but tells the consumer to write zeros instead of data. That request is raised on a separate flag output.

Top module: `wm_lane_mask`

## Requirements
- R1: In the wide format, lane width is 2^widthCode bytes (code 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B). The lane count is 64 divided by the lane width. Lane k covers bytes k*w up to k*w+w-1, and lane 0 holds byte 0 (mask bit 0). All bytes of one lane share one enable.
- R2: Wide format, mode 0: N of 0, 4 or 5 enables all lanes. N=1 enables only the odd-numbered lanes and N=2 enables only the even-numbered lanes. Any N above 5 enables no lanes.
- R3: Wide format, mode 0 with N=3 enables all lanes and drives `zeroFill` high. `zeroFill` is low for every other input combination.
- R4: Mode 1 enables only lane N. It enables no lane when N is at or above the lane count.
- R5: Mode 2 enables lanes 0 to N-1. When N is 0 it enables every lane.
- R6: Mode 3 enables the last N lanes (count-N to count-1). When N is 0 it enables every lane.
- R7: Wide format, mode 4 enables the first N lanes and mode 5 enables the last N lanes. With N=0 both modes enable no lane.
- R8: When N is at or above the lane count, every first-N or last-N selection (modes 2 to 5) enables all lanes.
- R9: Wide format, modes 6 and 7 enable no lane, whatever the value of N.
- R10: Narrow format (`wideFmt`=0): `modeIn[2]` and `valueIn[5]` have no effect. Mode 0 gives all lanes for N=0, odd lanes for N=1, even lanes for N=2 and no lanes otherwise. Modes 1 to 3 act as in R4 to R6.
- R11: Narrow format lane widths are: code 0 = 8 B, 1 = 4 B, 2 = 2 B, and 3 = 2 B with every odd-addressed byte disabled. Code 3 therefore gives the lane mask ANDed with 0x5555_5555_5555_5555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wideFmt | input | 1 | 1 selects the wide request format, 0 the narrow one |
| modeIn | input | 3 | Write-enable mode (narrow format uses bits 1:0) |
| valueIn | input | 6 | Value N (narrow format uses bits 4:0) |
| widthCode | input | 2 | Lane-width code, read per format as in R1 and R11 |
| byteEn | output | 64 | Byte enables, bit b for byte b of the row |
| zeroFill | output | 1 | Consumer must write zeros to the enabled bytes |

## Verification
Two functions can act on the same request. In the narrow format, the half-byte lane width (code 3) masks bytes on top of the lane selection from the mode. In the wide format, the force-zero flag and the all-lanes enable come from one single code. The bench sweeps every combination of format, mode, value and width code, so the byte-disable pattern always lands together with odd, even, first-N, last-N and single-lane masks. It judges both outputs against a behavioural model that works lane by lane and then byte by byte.

// File: rtl/wm_mask_pkg.sv
package wm_mask_pkg;
  localparam int ROW_BYTES = 64;
  localparam int CNT_W     = $clog2(ROW_BYTES) + 1;
  localparam int SHIFT_W   = 2;
  localparam int MODE_W    = 3;
  localparam int VAL_W     = 6;

  // decoded mode names
  typedef enum logic [MODE_W-1:0] {
    MD_PATTERN = 3'd0,
    MD_SINGLE  = 3'd1,
    MD_HEAD0   = 3'd2,
    MD_TAIL0   = 3'd3,
    MD_HEAD    = 3'd4,
    MD_TAIL    = 3'd5
  } wmMode_e;

  // strobes from decode to expansion
  typedef struct packed {
    logic               allOn;
    logic               oddOn;
    logic               evenOn;
    logic               singleOn;
    logic               firstOn;
    logic               lastOn;
    logic               halfByte;
    logic               zeroFill;
    logic [SHIFT_W-1:0] laneShift;
    logic [CNT_W-1:0]   laneCount;
    logic [CNT_W-1:0]   nVal;
  } wmStrobe_t;
endpackage

// File: rtl/wm_decode.sv
module wm_decode
  import wm_mask_pkg::*;
(
  input  logic              wideFmt,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [VAL_W-1:0]  valueIn,
  input  logic [1:0]        widthCode,
  output wmStrobe_t         strobes
);
  logic [MODE_W-1:0] modeEff;
  logic [VAL_W-1:0]  nEff;

  always_comb begin
    // the narrow format carries one fewer bit in each field
    modeEff = wideFmt ? modeIn : {1'b0, modeIn[MODE_W-2:0]};
    nEff    = wideFmt ? valueIn : {1'b0, valueIn[VAL_W-2:0]};

    strobes = '0;
    strobes.nVal = CNT_W'(nEff);
    if (wideFmt) begin
      strobes.laneShift = widthCode;
    end else if (widthCode == 2'd3) begin
      strobes.laneShift = SHIFT_W'(1);
      strobes.halfByte  = 1'b1;
    end else begin
      strobes.laneShift = SHIFT_W'(2'd3 - widthCode);
    end
    strobes.laneCount = CNT_W'(ROW_BYTES) >> strobes.laneShift;

    case (modeEff)
      MD_PATTERN: begin
        if (wideFmt) begin
          case (nEff)
            6'd0, 6'd4, 6'd5: strobes.allOn = 1'b1;
            6'd1:             strobes.oddOn = 1'b1;
            6'd2:             strobes.evenOn = 1'b1;
            6'd3: begin
              strobes.allOn    = 1'b1;
              strobes.zeroFill = 1'b1;
            end
            default: ;
          endcase
        end else begin
          case (nEff)
            6'd0:    strobes.allOn = 1'b1;
            6'd1:    strobes.oddOn = 1'b1;
            6'd2:    strobes.evenOn = 1'b1;
            default: ;
          endcase
        end
      end
      MD_SINGLE: strobes.singleOn = 1'b1;
      MD_HEAD0: begin
        if (nEff == '0) strobes.allOn = 1'b1;
        else            strobes.firstOn = 1'b1;
      end
      MD_TAIL0: begin
        if (nEff == '0) strobes.allOn = 1'b1;
        else            strobes.lastOn = 1'b1;
      end
      MD_HEAD: strobes.firstOn = 1'b1;
      MD_TAIL: strobes.lastOn = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/wm_expand.sv
module wm_expand
  import wm_mask_pkg::*;
(
  input  wmStrobe_t              strobes,
  output logic [ROW_BYTES-1:0]   byteEn,
  output logic                   zeroFill
);
  logic [CNT_W-1:0] tailStart;

  always_comb begin
    if (strobes.nVal >= strobes.laneCount) tailStart = '0;
    else                                   tailStart = strobes.laneCount - strobes.nVal;
  end

  assign zeroFill = strobes.zeroFill;

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    logic [CNT_W-1:0] laneIdx;
    logic             laneOn;
    assign laneIdx = CNT_W'(b) >> strobes.laneShift;
    assign laneOn  = strobes.allOn
                   | (strobes.oddOn    &  laneIdx[0])
                   | (strobes.evenOn   & ~laneIdx[0])
                   | (strobes.singleOn & (laneIdx == strobes.nVal))
                   | (strobes.firstOn  & (laneIdx <  strobes.nVal))
                   | (strobes.lastOn   & (laneIdx >= tailStart));
    if ((b % 2) == 1) begin : g_odd
      assign byteEn[b] = laneOn & ~strobes.halfByte;
    end else begin : g_even
      assign byteEn[b] = laneOn;
    end
  end
endmodule

// File: rtl/wm_lane_mask.sv
module wm_lane_mask
  import wm_mask_pkg::*;
(
  input  logic              wideFmt,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [VAL_W-1:0]  valueIn,
  input  logic [1:0]        widthCode,
  output logic [ROW_BYTES-1:0] byteEn,
  output logic              zeroFill
);
  wmStrobe_t strobes;

  wm_decode u_decode (
    .wideFmt   (wideFmt),
    .modeIn    (modeIn),
    .valueIn   (valueIn),
    .widthCode (widthCode),
    .strobes   (strobes)
  );

  wm_expand u_expand (
    .strobes  (strobes),
    .byteEn   (byteEn),
    .zeroFill (zeroFill)
  );
endmodule

// File: rtl/wm_lane_mask_chk.sv
module wm_lane_mask_chk
  import wm_mask_pkg::*;
(
  input logic                 wideFmt,
  input logic [MODE_W-1:0]    modeIn,
  input logic [VAL_W-1:0]     valueIn,
  input logic [1:0]           widthCode,
  input logic [ROW_BYTES-1:0] byteEn,
  input logic                 zeroFill
);
  logic laneUniform;

  always_comb begin
    laneUniform = 1'b1;
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (byteEn[b] != byteEn[(b >> widthCode) << widthCode]) laneUniform = 1'b0;
    end
  end

  always_comb begin
    if (wideFmt) AST_LANE_UNIFORM: assert (laneUniform); // R1
    if (zeroFill) AST_ZERO_FILL_ALL: assert (&byteEn); // R3
    if (zeroFill) AST_ZERO_FILL_WIDE: assert (wideFmt && modeIn == 3'd0 && valueIn == 6'd3); // R3
    if (wideFmt && modeIn >= 3'd6) AST_IDLE_MODES: assert (byteEn == '0); // R9
    if (wideFmt && (modeIn == 3'd4 || modeIn == 3'd5) && valueIn == '0)
      AST_EMPTY_HEAD_TAIL: assert (byteEn == '0); // R7
    if ((modeIn[1:0] == 2'd2 || modeIn[1:0] == 2'd3) && (wideFmt ? modeIn[2] == 1'b0 : 1'b1)
        && (wideFmt ? valueIn == '0 : valueIn[4:0] == '0) && !(!wideFmt && widthCode == 2'd3))
      AST_ZERO_N_ALL: assert (&byteEn); // R5
    if (!wideFmt && widthCode == 2'd3)
      AST_HALF_BYTE: assert ((byteEn & {(ROW_BYTES/2){2'b10}}) == '0); // R11
  end
endmodule

bind wm_lane_mask wm_lane_mask_chk u_chk (
  .wideFmt   (wideFmt),
  .modeIn    (modeIn),
  .valueIn   (valueIn),
  .widthCode (widthCode),
  .byteEn    (byteEn),
  .zeroFill  (zeroFill)
);

// File: tb/sim_wm_lane_mask.sv
module sim_wm_lane_mask;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wideFmt = 1'b0;
  logic [2:0]  modeIn = '0;
  logic [5:0]  valueIn = '0;
  logic [1:0]  widthCode = '0;
  logic [63:0] byteEn;
  logic        zeroFill;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wm_lane_mask u0 (
    .wideFmt(wideFmt), .modeIn(modeIn), .valueIn(valueIn),
    .widthCode(widthCode), .byteEn(byteEn), .zeroFill(zeroFill)
  );

  // behavioural model: decide per lane, then fan out to bytes
  task automatic model(input bit wf, input int md, input int v, input int wc,
                       output logic [63:0] m, output logic zf);
    int w, cnt, n, mode;
    bit half;
    bit laneOn [64];
    zf = 1'b0;
    half = 1'b0;
    if (wf) begin
      w = 1 << wc; mode = md; n = v;
    end else begin
      mode = md % 4; n = v % 32;
      case (wc)
        0: w = 8;
        1: w = 4;
        2: w = 2;
        default: begin w = 2; half = 1'b1; end
      endcase
    end
    cnt = 64 / w;
    for (int k = 0; k < cnt; k++) begin
      case (mode)
        0: begin
          if (n == 0) laneOn[k] = 1;
          else if (n == 1) laneOn[k] = (k % 2 == 1);
          else if (n == 2) laneOn[k] = (k % 2 == 0);
          else if (wf && (n == 3 || n == 4 || n == 5)) laneOn[k] = 1;
          else laneOn[k] = 0;
        end
        1: laneOn[k] = (k == n);
        2: laneOn[k] = (n == 0) || (k < n);
        3: laneOn[k] = (n == 0) || (k >= cnt - n);
        4: laneOn[k] = (k < n);
        5: laneOn[k] = (k >= cnt - n);
        default: laneOn[k] = 0;
      endcase
    end
    if (wf && mode == 0 && n == 3) zf = 1'b1;
    for (int b = 0; b < 64; b++) begin
      m[b] = laneOn[b / w];
      if (half && (b % 2 == 1)) m[b] = 1'b0;
    end
  endtask

  task automatic drive_and_check(input bit wf, input int md, input int v, input int wc,
                                 input string tag);
    logic [63:0] em;
    logic ez;
    @(posedge clk);
    wideFmt = wf; modeIn = 3'(md); valueIn = 6'(v); widthCode = 2'(wc);
    @(negedge clk);
    model(wf, md, v, wc, em, ez);
    checks++;
    if (byteEn !== em || zeroFill !== ez) begin
      errors++;
      $display("FAIL %s fmt=%0d mode=%0d n=%0d w=%0d: got %h/%0b expected %h/%0b",
               tag, wf, md, v, wc, byteEn, zeroFill, em, ez);
    end
  endtask

  function automatic string tagOf(input bit wf, input int md, input int v);
    if (!wf) return "R10";
    case (md)
      0: return (v == 3) ? "R3" : "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // reset state: narrow, mode 0, N 0 -> all lanes of 8 B
    @(negedge clk);
    checks++;
    if (byteEn !== '1 || zeroFill !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset state: got %h/%0b expected %h/0", byteEn, zeroFill, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    drive_and_check(1, 1, 3, 1, "R1");   // lane 3 of 2 B = bytes 6,7
    drive_and_check(1, 1, 0, 0, "R1");
    drive_and_check(1, 0, 1, 2, "R2");
    drive_and_check(1, 0, 2, 3, "R2");
    drive_and_check(1, 0, 9, 0, "R2");
    drive_and_check(1, 0, 3, 1, "R3");
    drive_and_check(1, 1, 8, 3, "R4");   // N beyond 8 lanes
    drive_and_check(1, 2, 0, 2, "R5");
    drive_and_check(1, 3, 5, 0, "R6");
    drive_and_check(1, 4, 0, 0, "R7");
    drive_and_check(1, 5, 0, 3, "R7");
    drive_and_check(1, 2, 40, 3, "R8");
    drive_and_check(1, 5, 63, 2, "R8");
    drive_and_check(1, 7, 12, 1, "R9");
    drive_and_check(0, 4, 33, 2, "R10"); // ignored top bits
    drive_and_check(0, 0, 3, 0, "R10");
    drive_and_check(0, 0, 0, 3, "R11");
    drive_and_check(0, 3, 4, 3, "R11");
    // full sweep, includes half-byte width against every mode
    for (int wf = 0; wf < 2; wf++)
      for (int md = 0; md < 8; md++)
        for (int v = 0; v < 64; v++)
          for (int wc = 0; wc < 4; wc++)
            drive_and_check(wf[0], md, v, wc, (!wf && wc == 3) ? "R11" : tagOf(wf[0], md, v));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule